// File: doc/BRIEF.md
# Multi-Mode Programmable Output Cell

This block is one output cell of a programmable logic device. A runtime type code sets its behaviour. It can pass a term straight through, act as a D, T, JK or RS flip-flop, act as a D flip-flop whose capture is qualified by an enable term, act as a latch that is open when its gate is low or when its gate is high, or act as a register whose function a control term switches between D and JK or between D and T.

All terms arrive as plain single-bit signals from the product-term array. The whole cell runs on one fabric clock. The clock term is sampled on that clock. A capture happens on the fabric edge where the sampled clock term is first seen high after being low; a parameter can move this to the high-to-low transition.

Reset, preset and load can each be marked absent, asynchronous or synchronous. An asynchronous control overrides the cell's value in the same cycle and writes the register on the next fabric edge. A synchronous control replaces the data function at a capture. The cell drives a pin value and a pin enable. It also returns the cell value, its complement, the data term and the pin value to the array.

Top module: `pld_macrocell`

## Requirements
- R1: When `cfg_mode` is 0, or is any code not listed in R2 to R8, `fb_q` equals `term_main` in the same cycle. The clock term and the control terms have no effect, and the stored value is kept.
- R2: When `cfg_mode` is 1 (D flip-flop), a capture stores `term_main`. The new value shows on `fb_q` after the fabric edge where `term_clk` is first sampled high after being low. If there is no such transition, the value does not change.
- R3: When `cfg_mode` is 2 (T flip-flop), a capture inverts the stored value if `term_main` is 1 and keeps it if `term_main` is 0.
- R4: When `cfg_mode` is 3 (JK flip-flop), J is `term_main` and K is `term_sec`. At a capture: J=1, K=0 sets; J=0, K=1 clears; both 0 holds; both 1 toggles.
- R5: When `cfg_mode` is 5 (RS flip-flop), Set is `term_main` and Reset is `term_sec`. At a capture, Set alone sets and Reset alone clears. Both active, or both idle, hold the value.
- R6: When `cfg_mode` is 11 (D flip-flop with enable), a capture takes place only if `term_ce` is 1 at that fabric edge.
- R7: When `cfg_mode` is 12, the latch is open while `term_clk` is 1. When `cfg_mode` is 7, the latch is open while `term_clk` is 0. While the latch is open, `fb_q` follows `term_main` in the same cycle. While it is closed, `fb_q` holds the value registered at the last fabric edge when the latch was open.
- R8: The function control is `cfg_fc_en & term_fc`. When `cfg_mode` is 4, control 0 selects D and control 1 selects JK. When `cfg_mode` is 15 or 16, `cfg_dyn` decides the switch:
  - 1: D, then JK when control is 1
  - 2: JK, then D when control is 1
  - 3: D, then T when control is 1
  - 4: T, then D when control is 1
  - any other value: D
- R9: The control bit order is: bit 0 reset, bit 1 preset, bit 2 load. For any storage mode, a control whose `cfg_ctl_en` bit is 1 and whose `cfg_ctl_sync` bit is 0 is asynchronous. While its term is 1, it forces `fb_q` in the same cycle: reset forces 0, preset forces 1, load forces `pin_in`. Reset has the highest priority, then preset, then load. The register keeps the forced value after the control is released.
- R10: A control whose `cfg_ctl_en` and `cfg_ctl_sync` bits are both 1 is synchronous. If its term is active at a capture (or, for a latch, while the latch is open), it replaces the data function. The priority order is the same as in R9.
- R11: A control whose `cfg_ctl_en` bit is 0 has no effect, whatever its term does.
- R12: The buffer code `cfg_obuf` works as follows:
  - 1: `pin_out` = `fb_q`
  - 2: `pin_out` = `~fb_q`
  - 0 or 3: `pin_out` = 0 and `pin_oe` = 0

  With a used buffer, `pin_oe` is `term_oe` when `cfg_oe_en` is 1, and is 1 when `cfg_oe_en` is 0.
- R13: `fb_qn` is always the complement of `fb_q`. `fb_data` equals `term_main` and `fb_pin` equals `pin_in`.
- R14: While `rst_n` is low, the stored value is 0. A clock term that is held high through reset release does not cause a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low fabric reset |
| cfg_mode | input | MODE_W | Cell type code |
| cfg_dyn | input | DYN_W | Switch kind for programmable mode |
| cfg_obuf | input | OBUF_W | Output buffer code |
| cfg_oe_en | input | 1 | Output enable term present |
| cfg_fc_en | input | 1 | Function control term present |
| cfg_ctl_en | input | 3 | Presence of reset, preset, load (bits 0..2) |
| cfg_ctl_sync | input | 3 | 1 = synchronous, 0 = asynchronous, per control |
| term_main | input | 1 | Main data term (D, T, J, Set, latch data) |
| term_sec | input | 1 | Second data term (K, Reset) |
| term_clk | input | 1 | Clock or latch gate term |
| term_ce | input | 1 | Clock enable term |
| term_oe | input | 1 | Output enable term |
| term_fc | input | 1 | Function control term |
| term_ctl | input | 3 | Reset, preset, load terms (bits 0..2) |
| pin_in | input | 1 | Value present on the pad |
| pin_out | output | 1 | Buffered cell value to the pad |
| pin_oe | output | 1 | Pad drive enable |
| fb_q | output | 1 | Cell value feedback |
| fb_qn | output | 1 | Complemented cell value feedback |
| fb_data | output | 1 | Data term feedback |
| fb_pin | output | 1 | Pad value feedback |

## Verification
The in-line assertions check the following on every cycle: that a combinational cell passes its main term, that an active asynchronous reset wins over everything in a storage mode, that a flip-flop does not move without a capture or while its enable is low, that RS with both inputs active holds, that JK with both inputs high toggles, and that a missing output enable leaves the pad driven. Only the bench's reference model, compared on every clock, can show the following: the exact cycle of each capture, latch transparency and hold, the D/JK and D/T switch under each dynamic code, the priority order among controls, load taking the pad value, and the behaviour over long mixed sequences where the mode changes.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

   localparam int NUM_CTL = 3;
   localparam int CTL_RST = 0;
   localparam int CTL_PRE = 1;
   localparam int CTL_LD  = 2;

   localparam int MD_COMB   = 0;
   localparam int MD_DFF    = 1;
   localparam int MD_TFF    = 2;
   localparam int MD_JKFF   = 3;
   localparam int MD_JKD    = 4;
   localparam int MD_RSFF   = 5;
   localparam int MD_LAT_LO = 7;
   localparam int MD_DFF_CE = 11;
   localparam int MD_LAT_HI = 12;
   localparam int MD_PROG_A = 15;
   localparam int MD_PROG_B = 16;

   localparam int DY_D_JK = 1;
   localparam int DY_JK_D = 2;
   localparam int DY_D_T  = 3;
   localparam int DY_T_D  = 4;

   localparam int OB_NORM = 1;
   localparam int OB_INV  = 2;

   typedef enum logic [1:0] {K_COMB, K_FLOP, K_LATCH} cell_kind_e;
   typedef enum logic [1:0] {FN_D, FN_T, FN_JK, FN_RS} cell_fn_e;

endpackage

// File: rtl/pld_mc_mode_decode.sv
module pld_mc_mode_decode
   import pld_mc_pkg::*;
#(
   parameter int MODE_W = 5,
   parameter int DYN_W  = 3
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [DYN_W-1:0]  dyn,
   input  logic              fc,
   output cell_kind_e        kind,
   output cell_fn_e          fn,
   output logic              lat_open_hi,
   output logic              need_ce
);

   cell_fn_e prog_fn;

   always_comb begin
      prog_fn = FN_D;
      case (dyn)
         DYN_W'(DY_D_JK): prog_fn = fc ? FN_JK : FN_D;
         DYN_W'(DY_JK_D): prog_fn = fc ? FN_D  : FN_JK;
         DYN_W'(DY_D_T):  prog_fn = fc ? FN_T  : FN_D;
         DYN_W'(DY_T_D):  prog_fn = fc ? FN_D  : FN_T;
         default:         prog_fn = FN_D;
      endcase
   end

   always_comb begin
      kind        = K_COMB;
      fn          = FN_D;
      lat_open_hi = 1'b0;
      need_ce     = 1'b0;
      case (mode)
         MODE_W'(MD_DFF):    kind = K_FLOP;
         MODE_W'(MD_TFF):    begin kind = K_FLOP; fn = FN_T;  end
         MODE_W'(MD_JKFF):   begin kind = K_FLOP; fn = FN_JK; end
         MODE_W'(MD_RSFF):   begin kind = K_FLOP; fn = FN_RS; end
         MODE_W'(MD_DFF_CE): begin kind = K_FLOP; need_ce = 1'b1; end
         MODE_W'(MD_JKD):    begin kind = K_FLOP; fn = fc ? FN_JK : FN_D; end
         MODE_W'(MD_LAT_LO): kind = K_LATCH;
         MODE_W'(MD_LAT_HI): begin kind = K_LATCH; lat_open_hi = 1'b1; end
         MODE_W'(MD_PROG_A),
         MODE_W'(MD_PROG_B): begin kind = K_FLOP; fn = prog_fn; end
         default:            kind = K_COMB;
      endcase
   end

endmodule

// File: rtl/pld_mc_ctl_resolve.sv
module pld_mc_ctl_resolve
   import pld_mc_pkg::*;
#(
   parameter int N_CTL = NUM_CTL
) (
   input  logic [N_CTL-1:0] en,
   input  logic [N_CTL-1:0] sync,
   input  logic [N_CTL-1:0] term,
   input  logic             pin,
   output logic             a_hit,
   output logic             a_val,
   output logic             s_hit,
   output logic             s_val
);

   logic [N_CTL-1:0] a_act;
   logic [N_CTL-1:0] s_act;
   logic [N_CTL-1:0] force_val;

   if (N_CTL != 3) begin : g_bad_count
      $error("pld_mc_ctl_resolve: exactly three controls are supported");
   end

   for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
      assign a_act[i] = en[i] & ~sync[i] & term[i];
      assign s_act[i] = en[i] &  sync[i] & term[i];
      if (i == CTL_RST) begin : g_rst
         assign force_val[i] = 1'b0;
      end else if (i == CTL_PRE) begin : g_pre
         assign force_val[i] = 1'b1;
      end else begin : g_ld
         assign force_val[i] = pin;
      end
   end

   // lowest index is applied last, so it has the highest priority
   always_comb begin
      a_val = 1'b0;
      s_val = 1'b0;
      for (int i = N_CTL - 1; i >= 0; i--) begin
         if (a_act[i]) a_val = force_val[i];
         if (s_act[i]) s_val = force_val[i];
      end
   end

   assign a_hit = |a_act;
   assign s_hit = |s_act;

endmodule

// File: rtl/pld_mc_storage.sv
module pld_mc_storage
   import pld_mc_pkg::*;
#(
   parameter bit CLK_RISE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cell_kind_e kind,
   input  cell_fn_e   fn,
   input  logic       lat_open_hi,
   input  logic       need_ce,
   input  logic       t_main,
   input  logic       t_sec,
   input  logic       t_clk,
   input  logic       t_ce,
   input  logic       a_hit,
   input  logic       a_val,
   input  logic       s_hit,
   input  logic       s_val,
   output logic       cell_v
);

   localparam logic PREV_RST = CLK_RISE ? 1'b1 : 1'b0;

   logic state_q, state_d;
   logic clk_prev_q;
   logic cap_evt, cap_ok, lat_open;
   logic fn_next, data_next;

   if (CLK_RISE) begin : g_rise
      assign cap_evt = t_clk & ~clk_prev_q;
   end else begin : g_fall
      assign cap_evt = ~t_clk & clk_prev_q;
   end

   assign cap_ok   = cap_evt & (~need_ce | t_ce);
   assign lat_open = lat_open_hi ? t_clk : ~t_clk;

   always_comb begin
      fn_next = state_q;
      case (fn)
         FN_D:  fn_next = t_main;
         FN_T:  fn_next = state_q ^ t_main;
         FN_JK: case ({t_main, t_sec})
                   2'b10:   fn_next = 1'b1;
                   2'b01:   fn_next = 1'b0;
                   2'b11:   fn_next = ~state_q;
                   default: fn_next = state_q;
                endcase
         FN_RS: case ({t_main, t_sec})
                   2'b10:   fn_next = 1'b1;
                   2'b01:   fn_next = 1'b0;
                   default: fn_next = state_q;
                endcase
         default: fn_next = state_q;
      endcase
   end

   always_comb begin
      if (s_hit)
         data_next = s_val;
      else if (kind == K_LATCH)
         data_next = t_main;
      else
         data_next = fn_next;
   end

   always_comb begin
      state_d = state_q;
      cell_v  = state_q;
      case (kind)
         K_LATCH: begin
            if (a_hit) begin
               state_d = a_val;
               cell_v  = a_val;
            end else if (lat_open) begin
               state_d = data_next;
               cell_v  = data_next;
            end
         end
         K_FLOP: begin
            if (a_hit) begin
               state_d = a_val;
               cell_v  = a_val;
            end else if (cap_ok) begin
               state_d = data_next;
            end
         end
         default: cell_v = t_main;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= 1'b0;
         clk_prev_q <= PREV_RST;
      end else begin
         state_q    <= state_d;
         clk_prev_q <= t_clk;
      end
   end

   AST_FLOP_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_FLOP && !cap_evt && !a_hit) |=> $stable(state_q)); // R2

   AST_CE_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_FLOP && need_ce && !t_ce && !a_hit) |=> $stable(state_q)); // R6

   AST_RS_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_FLOP && fn == FN_RS && cap_ok && t_main && t_sec && !a_hit && !s_hit)
      |=> $stable(state_q)); // R5

   AST_JK_BOTH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_FLOP && fn == FN_JK && cap_ok && t_main && t_sec && !a_hit && !s_hit)
      |=> (state_q != $past(state_q))); // R4

endmodule

// File: rtl/pld_mc_out_buf.sv
module pld_mc_out_buf
   import pld_mc_pkg::*;
#(
   parameter int OBUF_W = 2
) (
   input  logic [OBUF_W-1:0] obuf,
   input  logic              oe_en,
   input  logic              t_oe,
   input  logic              v,
   output logic              pin_out,
   output logic              pin_oe
);

   logic is_norm, is_inv, used;

   assign is_norm = (obuf == OBUF_W'(OB_NORM));
   assign is_inv  = (obuf == OBUF_W'(OB_INV));
   assign used    = is_norm | is_inv;

   assign pin_out = used & (v ^ is_inv);
   assign pin_oe  = used & (~oe_en | t_oe);

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
   import pld_mc_pkg::*;
#(
   parameter int MODE_W   = 5,
   parameter int DYN_W    = 3,
   parameter int OBUF_W   = 2,
   parameter bit CLK_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic [DYN_W-1:0]  cfg_dyn,
   input  logic [OBUF_W-1:0] cfg_obuf,
   input  logic              cfg_oe_en,
   input  logic              cfg_fc_en,
   input  logic [2:0]        cfg_ctl_en,
   input  logic [2:0]        cfg_ctl_sync,
   input  logic              term_main,
   input  logic              term_sec,
   input  logic              term_clk,
   input  logic              term_ce,
   input  logic              term_oe,
   input  logic              term_fc,
   input  logic [2:0]        term_ctl,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              fb_q,
   output logic              fb_qn,
   output logic              fb_data,
   output logic              fb_pin
);

   if (MODE_W < 5) begin : g_bad_mode_w
      $error("pld_macrocell: MODE_W must hold code 16");
   end
   if (DYN_W < 3) begin : g_bad_dyn_w
      $error("pld_macrocell: DYN_W must hold code 4");
   end
   if (OBUF_W < 2) begin : g_bad_obuf_w
      $error("pld_macrocell: OBUF_W must hold code 2");
   end

   cell_kind_e cell_kind;
   cell_fn_e   cell_fn;
   logic       lat_open_hi, need_ce, fc_eff;
   logic       a_hit, a_val, s_hit, s_val;
   logic       cell_v;

   assign fc_eff = cfg_fc_en & term_fc;

   pld_mc_mode_decode #(.MODE_W(MODE_W), .DYN_W(DYN_W)) u_dec (
      .mode        (cfg_mode),
      .dyn         (cfg_dyn),
      .fc          (fc_eff),
      .kind        (cell_kind),
      .fn          (cell_fn),
      .lat_open_hi (lat_open_hi),
      .need_ce     (need_ce)
   );

   pld_mc_ctl_resolve #(.N_CTL(NUM_CTL)) u_ctl (
      .en    (cfg_ctl_en),
      .sync  (cfg_ctl_sync),
      .term  (term_ctl),
      .pin   (pin_in),
      .a_hit (a_hit),
      .a_val (a_val),
      .s_hit (s_hit),
      .s_val (s_val)
   );

   pld_mc_storage #(.CLK_RISE(CLK_RISE)) u_sto (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind        (cell_kind),
      .fn          (cell_fn),
      .lat_open_hi (lat_open_hi),
      .need_ce     (need_ce),
      .t_main      (term_main),
      .t_sec       (term_sec),
      .t_clk       (term_clk),
      .t_ce        (term_ce),
      .a_hit       (a_hit),
      .a_val       (a_val),
      .s_hit       (s_hit),
      .s_val       (s_val),
      .cell_v      (cell_v)
   );

   pld_mc_out_buf #(.OBUF_W(OBUF_W)) u_obuf (
      .obuf    (cfg_obuf),
      .oe_en   (cfg_oe_en),
      .t_oe    (term_oe),
      .v       (cell_v),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   assign fb_q    = cell_v;
   assign fb_qn   = ~cell_v;
   assign fb_data = term_main;
   assign fb_pin  = pin_in;

   AST_COMB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_kind == K_COMB) |-> (fb_q == term_main)); // R1

   AST_ASYNC_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_kind != K_COMB && cfg_ctl_en[CTL_RST] && !cfg_ctl_sync[CTL_RST] && term_ctl[CTL_RST])
      |-> !fb_q); // R9

   AST_OE_ABSENT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_obuf == OBUF_W'(OB_NORM) && !cfg_oe_en) |-> pin_oe); // R12

endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] cfg_mode;
   logic [2:0] cfg_dyn;
   logic [1:0] cfg_obuf;
   logic       cfg_oe_en, cfg_fc_en;
   logic [2:0] cfg_ctl_en, cfg_ctl_sync;
   logic       term_main, term_sec, term_clk, term_ce, term_oe, term_fc;
   logic [2:0] term_ctl;
   logic       pin_in;
   logic       pin_out, pin_oe, fb_q, fb_qn, fb_data, fb_pin;

   always #10 clk = ~clk;

   pld_macrocell dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dyn(cfg_dyn),
      .cfg_obuf(cfg_obuf), .cfg_oe_en(cfg_oe_en), .cfg_fc_en(cfg_fc_en),
      .cfg_ctl_en(cfg_ctl_en), .cfg_ctl_sync(cfg_ctl_sync),
      .term_main(term_main), .term_sec(term_sec), .term_clk(term_clk),
      .term_ce(term_ce), .term_oe(term_oe), .term_fc(term_fc),
      .term_ctl(term_ctl), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .fb_q(fb_q), .fb_qn(fb_qn),
      .fb_data(fb_data), .fb_pin(fb_pin)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int unsigned seed = 32'h1234_5678;

   // reference model state
   bit m_q    = 1'b0;
   bit m_prev = 1'b1;

   function automatic int unsigned rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   function automatic bit jk_step(bit q, bit j, bit k);
      if (j && k) return !q;
      if (j) return 1'b1;
      if (k) return 1'b0;
      return q;
   endfunction

   task automatic tick(input string tag);
      int  md, fnc;
      bit  is_flop, is_latch, fcx, a_hit, a_val, s_hit, s_val;
      bit  v, nq, open, fx, okb;
      bit  e_out, e_oe;
      #5;
      md = int'(cfg_mode);
      is_flop  = (md == 1 || md == 2 || md == 3 || md == 4 || md == 5 ||
                  md == 11 || md == 15 || md == 16);
      is_latch = (md == 7 || md == 12);
      fcx = cfg_fc_en && term_fc;
      fnc = 0; // 0 D, 1 T, 2 JK, 3 RS
      if (md == 2) fnc = 1;
      if (md == 3) fnc = 2;
      if (md == 5) fnc = 3;
      if (md == 4) fnc = fcx ? 2 : 0;
      if (md == 15 || md == 16) begin
         case (int'(cfg_dyn))
            1: fnc = fcx ? 2 : 0;
            2: fnc = fcx ? 0 : 2;
            3: fnc = fcx ? 1 : 0;
            4: fnc = fcx ? 0 : 1;
            default: fnc = 0;
         endcase
      end
      a_hit = 1'b0; a_val = 1'b0; s_hit = 1'b0; s_val = 1'b0;
      for (int c = 2; c >= 0; c--) begin
         if (cfg_ctl_en[c] && term_ctl[c]) begin
            bit fv;
            fv = (c == 0) ? 1'b0 : (c == 1) ? 1'b1 : pin_in;
            if (cfg_ctl_sync[c]) begin s_hit = 1'b1; s_val = fv; end
            else begin a_hit = 1'b1; a_val = fv; end
         end
      end
      nq = m_q;
      v  = m_q;
      if (!is_flop && !is_latch) begin
         v = term_main;
      end else if (a_hit) begin
         v = a_val; nq = a_val;
      end else if (is_latch) begin
         open = (md == 12) ? term_clk : !term_clk;
         if (open) begin
            v = s_hit ? s_val : term_main;
            nq = v;
         end
      end else if (term_clk && !m_prev && (md != 11 || term_ce)) begin
         case (fnc)
            0: fx = term_main;
            1: fx = m_q ^ term_main;
            2: fx = jk_step(m_q, term_main, term_sec);
            default: fx = (term_main && !term_sec) ? 1'b1 :
                          (!term_main && term_sec) ? 1'b0 : m_q;
         endcase
         nq = s_hit ? s_val : fx;
      end
      okb   = (cfg_obuf == 2'd1) || (cfg_obuf == 2'd2);
      e_out = okb && (v ^ (cfg_obuf == 2'd2));
      e_oe  = okb && (!cfg_oe_en || term_oe);
      n_cmp++;
      if ({pin_out, pin_oe, fb_q, fb_qn, fb_data, fb_pin} !==
          {e_out, e_oe, v, !v, term_main, pin_in}) begin
         n_bad++;
         $display("FAIL %s t=%0t mode=%0d out/oe/q/qn/data/pin actual=%b%b%b%b%b%b expected=%b%b%b%b%b%b",
                  tag, $time, md, pin_out, pin_oe, fb_q, fb_qn, fb_data, fb_pin,
                  e_out, e_oe, v, !v, term_main, pin_in);
      end
      @(posedge clk);
      if (!rst_n) begin
         m_q = 1'b0; m_prev = 1'b1;
      end else begin
         m_q = nq; m_prev = term_clk;
      end
      #1;
   endtask

   task automatic pulse(input string tag);
      term_clk = 1'b1; tick(tag);
      term_clk = 1'b0; tick(tag);
   endtask

   task automatic idle();
      cfg_dyn = 3'd0; cfg_obuf = 2'd1; cfg_oe_en = 1'b0; cfg_fc_en = 1'b0;
      cfg_ctl_en = 3'b000; cfg_ctl_sync = 3'b000;
      term_main = 1'b0; term_sec = 1'b0; term_ce = 1'b0; term_oe = 1'b0;
      term_fc = 1'b0; term_ctl = 3'b000; pin_in = 1'b0;
   endtask

   function automatic string mode_tag(int md);
      case (md)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         5: return "R5";
         11: return "R6";
         7, 12: return "R7";
         4, 15, 16: return "R8";
         default: return "R1";
      endcase
   endfunction

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired compared=%0d", n_cmp);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int codes[12] = '{0, 1, 2, 3, 4, 5, 7, 11, 12, 15, 16, 9};
      rst_n = 1'b0; idle(); cfg_mode = 5'd1; term_clk = 1'b1; term_main = 1'b1;
      // R14: reset state, clock term held high across release
      repeat (3) tick("R14");
      rst_n = 1'b1;
      tick("R14"); tick("R14");
      term_clk = 1'b0; tick("R14");

      // R1: combinational and unknown codes ignore clock and controls
      foreach (codes[k]) if (codes[k] == 0 || codes[k] == 9) begin
         cfg_mode = 5'(codes[k]); cfg_ctl_en = 3'b111;
         for (int i = 0; i < 8; i++) begin
            term_main = i[0]; term_clk = i[1]; term_ctl = {i[2], i[1], i[0]};
            tick("R1");
         end
      end
      idle(); term_clk = 1'b0; tick("R1");

      // R2: D flip-flop
      cfg_mode = 5'd1;
      term_main = 1'b1; pulse("R2");
      term_main = 1'b0; tick("R2"); tick("R2");
      pulse("R2");
      term_main = 1'b1; term_clk = 1'b1; tick("R2"); term_main = 1'b0; tick("R2");
      term_clk = 1'b0; tick("R2");

      // R3: T flip-flop
      cfg_mode = 5'd2; term_main = 1'b1;
      repeat (3) pulse("R3");
      term_main = 1'b0; pulse("R3");

      // R4: JK including toggle
      cfg_mode = 5'd3;
      for (int i = 0; i < 6; i++) begin
         {term_main, term_sec} = (i == 0) ? 2'b10 : (i == 1) ? 2'b00 :
                                 (i == 2) ? 2'b01 : 2'b11;
         pulse("R4");
      end

      // R5: RS with both active holding
      cfg_mode = 5'd5;
      {term_main, term_sec} = 2'b10; pulse("R5");
      {term_main, term_sec} = 2'b11; pulse("R5");
      {term_main, term_sec} = 2'b01; pulse("R5");
      {term_main, term_sec} = 2'b11; pulse("R5");
      {term_main, term_sec} = 2'b00; pulse("R5");

      // R6: gated D
      cfg_mode = 5'd11; term_sec = 1'b0;
      term_main = 1'b1; term_ce = 1'b0; pulse("R6");
      term_ce = 1'b1; pulse("R6");
      term_main = 1'b0; term_ce = 1'b0; pulse("R6");
      term_ce = 1'b1; pulse("R6");

      // R7: latches, both polarities
      cfg_mode = 5'd12; term_clk = 1'b1;
      for (int i = 0; i < 4; i++) begin term_main = i[0]; tick("R7"); end
      term_main = 1'b1; tick("R7"); term_clk = 1'b0; tick("R7");
      term_main = 1'b0; tick("R7"); tick("R7");
      cfg_mode = 5'd7;
      for (int i = 0; i < 4; i++) begin term_main = !i[0]; tick("R7"); end
      term_clk = 1'b1; term_main = 1'b1; tick("R7"); tick("R7");
      term_clk = 1'b0; tick("R7");

      // R8: function switching
      cfg_fc_en = 1'b1;
      for (int md = 0; md < 3; md++) begin
         cfg_mode = (md == 0) ? 5'd4 : (md == 1) ? 5'd15 : 5'd16;
         for (int dy = 0; dy < 6; dy++) begin
            cfg_dyn = 3'(dy);
            for (int f = 0; f < 2; f++) begin
               term_fc = f[0];
               {term_main, term_sec} = 2'b11; pulse("R8");
               {term_main, term_sec} = 2'b01; pulse("R8");
               {term_main, term_sec} = 2'b10; pulse("R8");
            end
         end
      end
      cfg_fc_en = 1'b0; term_fc = 1'b1; cfg_dyn = 3'd1; cfg_mode = 5'd15;
      {term_main, term_sec} = 2'b11; pulse("R8"); pulse("R8");

      // R9: asynchronous controls and priority
      idle(); cfg_mode = 5'd1; cfg_ctl_en = 3'b111; cfg_ctl_sync = 3'b000;
      for (int i = 1; i < 8; i++) begin
         term_ctl = 3'(i); pin_in = i[1]; term_main = !i[0];
         tick("R9"); pulse("R9");
         term_ctl = 3'b000; tick("R9");
      end
      cfg_mode = 5'd12; term_clk = 1'b1; term_main = 1'b1; term_ctl = 3'b001; tick("R9");
      term_ctl = 3'b000; tick("R9"); term_clk = 1'b0; tick("R9");

      // R10: synchronous controls and priority
      cfg_mode = 5'd1; cfg_ctl_sync = 3'b111;
      for (int i = 1; i < 8; i++) begin
         term_ctl = 3'(i); pin_in = !i[1]; term_main = i[0];
         tick("R10"); pulse("R10");
      end
      cfg_mode = 5'd12; term_ctl = 3'b010; term_main = 1'b0; term_clk = 1'b1; tick("R10");
      term_clk = 1'b0; tick("R10"); term_ctl = 3'b000;

      // R11: absent controls ignored
      cfg_mode = 5'd1; cfg_ctl_en = 3'b000;
      for (int i = 0; i < 4; i++) begin
         term_ctl = 3'b111; pin_in = i[0]; term_main = i[1];
         tick("R11"); pulse("R11");
      end

      // R12 and R13: buffer codes, output enable, feedbacks
      idle(); cfg_mode = 5'd0;
      for (int i = 0; i < 64; i++) begin
         cfg_obuf = 2'(i); cfg_oe_en = i[2]; term_oe = i[3];
         term_main = i[4]; pin_in = i[5];
         tick(i[5] ? "R13" : "R12");
      end

      // mixed soak across all modes
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         r = rnd();
         if (n % 12 == 0) cfg_mode = 5'(codes[(r >> 8) % 12]);
         cfg_dyn = 3'(r >> 3); cfg_obuf = 2'(r >> 6);
         cfg_oe_en = r[9]; cfg_fc_en = r[10];
         cfg_ctl_en = (r[11] && r[12]) ? 3'(r >> 13) : 3'b000;
         cfg_ctl_sync = 3'(r >> 16);
         term_main = r[19]; term_sec = r[20]; term_clk = r[21];
         term_ce = r[22]; term_oe = r[23]; term_fc = r[24];
         term_ctl = 3'(r >> 25) & 3'(r >> 28); pin_in = r[31];
         tick(mode_tag(int'(cfg_mode)));
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule